// File: doc/BRIEF.md
# UART Interrupt Status and Priority Controller

This block generates the interrupt request line and the read-only interrupt status byte for a single UART channel. Five event sources feed it: line errors, receive FIFO at or above its trigger level, receive character timeout, transmit FIFO empty, and modem-line changes. Each source keeps its own pending bit. The status byte reports only the highest-priority source that is both pending and enabled. The other pending sources stay queued until the higher ones are serviced.

Each source has its own clearing side effect. A read of the line status register, the modem status register, the receive holding register or the status byte itself clears a source, and so does a write to the transmit holding register. The surrounding UART reports these accesses on one-cycle strobes. The block also times the receive idle period. A bit-time tick advances a counter, and the counter's limit is derived from the configured character length.

Top module: `uart_irq_status`

## Requirements
- R1: After a synchronous active-low reset, no source is pending. The status code in bits 3:0 reads 0001, with bit 0 = 1 meaning nothing pending, and `irq` is low.
- R2: All pending state is registered, so an event appears in the status byte one clock after the edge that samples it. Bits 3:0 show the highest-priority source that is both pending and enabled. The order from highest to lowest, with its code, is: line error 0110, receive timeout 1100, receive ready 0100, transmit ready 0010, modem change 0000.
- R3: Bits 7:6 both equal `fifo_en` combinationally. Bits 5:4 always read 0.
- R4: Source enable bits are `src_en[0]` line, `[1]` timeout, `[2]` receive ready, `[3]` transmit ready, `[4]` modem. `irq` is high exactly when some enabled source is pending. A disabled source never appears in the code, but it stays pending and shows once it is enabled.
- R5: A line-error interrupt is latched when any bit of `line_flags` goes from 0 to 1. A `lsr_rd` strobe clears it. A new rising flag in the same cycle as `lsr_rd` wins, and the interrupt stays pending.
- R6: A modem interrupt is latched when any bit of `modem_flags` goes from 0 to 1. A `msr_rd` strobe clears it. A new rising flag in the same cycle wins.
- R7: Receive ready is pending while `rx_count >= rx_trigger` with FIFOs enabled, or while `rx_count >= 1` with FIFOs disabled. It clears as soon as the count drops below that level.
- R8: Receive timeout becomes pending on the (4*`char_bits`+12)-th `bit_tick`. Ticks are counted only while `fifo_en` is high and `rx_count` is nonzero.
- R9: An `rx_push` or an `rx_pop` restarts the timeout count from zero.
- R10: An `rx_pop` (receive holding register read) clears a pending timeout.
- R11: Transmit ready is latched when `tx_empty` rises. A `thr_wr` clears it, and the clear wins over a same-cycle rise.
- R12: An `isr_rd` clears transmit ready only when transmit ready is the code being reported in that cycle. It clears no other source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled |
| src_en | input | 5 | Per-source interrupt enables |
| line_flags | input | 4 | Line error flags |
| modem_flags | input | 4 | Modem change flags |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trigger | input | CNT_W | Receive trigger level |
| rx_push | input | 1 | Character written into receive FIFO |
| rx_pop | input | 1 | Receive holding register read strobe |
| bit_tick | input | 1 | One pulse per bit time |
| char_bits | input | CLEN_W | Character frame length in bits |
| tx_empty | input | 1 | Transmit FIFO empty |
| thr_wr | input | 1 | Transmit holding register write strobe |
| isr_rd | input | 1 | Status byte read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| isr_byte | output | 8 | Interrupt status byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every access input is a one-cycle strobe, sampled at the same edge as the flags it relates to. They also assume that `rx_count` is a settled FIFO level that does not glitch between edges. The bench drives every input one time unit after a rising edge and holds it for whole cycles. Strobes are pulsed for exactly one clock, and flag edges are produced by raising a flag for one clock and dropping it again. The 32×32 sweep only changes `src_en` between edges while all other inputs are idle, so the pending state it reads back stays fixed.

// File: rtl/uirq_pkg.sv
// Package: shared source indices and status codes for the UART interrupt
// status controller. Assumes five sources ordered by priority, index 0 highest.
package uirq_pkg;
    localparam int NSRC = 5;

    localparam logic [2:0] IDX_LINE  = 3'd0;
    localparam logic [2:0] IDX_RXTO  = 3'd1;
    localparam logic [2:0] IDX_RXRDY = 3'd2;
    localparam logic [2:0] IDX_TXRDY = 3'd3;
    localparam logic [2:0] IDX_MODEM = 3'd4;

    localparam logic [3:0] CODE_LINE  = 4'b0110;
    localparam logic [3:0] CODE_RXTO  = 4'b1100;
    localparam logic [3:0] CODE_RXRDY = 4'b0100;
    localparam logic [3:0] CODE_TXRDY = 4'b0010;
    localparam logic [3:0] CODE_MODEM = 4'b0000;
    localparam logic [3:0] CODE_NONE  = 4'b0001;

    // Map a source index to its four-bit status code.
    function automatic logic [3:0] src_code(input logic [2:0] idx);
        case (idx)
            IDX_LINE:  return CODE_LINE;
            IDX_RXTO:  return CODE_RXTO;
            IDX_RXRDY: return CODE_RXRDY;
            IDX_TXRDY: return CODE_TXRDY;
            IDX_MODEM: return CODE_MODEM;
            default:   return CODE_NONE;
        endcase
    endfunction
endpackage

// File: rtl/uirq_edge_latch.sv
// Module: uirq_edge_latch
// Latches a pending flag when any bit of a flag vector rises from 0 to 1.
// A clear strobe drops the flag unless a new rise arrives in the same cycle.
// Assumes clr is a one-cycle strobe.
module uirq_edge_latch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flags,
    input  logic         clr,
    output logic         pend
);
    logic [W-1:0] prev_q;
    logic         rise;

    // Detect a fresh rise on any flag bit.
    always_comb rise = |(flags & ~prev_q);

    // Remember last flag values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= flags;
    end

    // Pending flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= 1'b0;
        else if (rise) pend <= 1'b1;
        else if (clr)  pend <= 1'b0;
    end
endmodule

// File: rtl/uirq_timeout.sv
// Module: uirq_timeout
// Receive idle timer. Counts bit ticks while the FIFO mode is on and the
// receive FIFO holds data; raises pending on tick number 4*char_bits+12.
// Any push or pop restarts the count; a pop clears the pending flag.
module uirq_timeout #(
    parameter int CNT_W  = 5,
    parameter int CLEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              rx_push,
    input  logic              rx_pop,
    input  logic              bit_tick,
    input  logic [CLEN_W-1:0] char_bits,
    output logic              to_pend
);
    localparam int TO_W = CLEN_W + 3;

    logic [TO_W-1:0] limit;
    logic [TO_W-1:0] cnt_q;
    logic            restart;
    logic            hit;

    // Limit in bit times: four characters plus twelve bits.
    always_comb limit = {1'b0, char_bits, 2'b00} + TO_W'(12);

    // Restart on FIFO activity, empty FIFO or FIFO mode off.
    always_comb restart = rx_push | rx_pop | ~fifo_en | (rx_count == '0);

    // The tick that completes the window.
    always_comb hit = ~restart & bit_tick & (cnt_q == limit - TO_W'(1));

    // Idle tick counter, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (restart)                    cnt_q <= '0;
        else if (bit_tick && cnt_q < limit)  cnt_q <= cnt_q + TO_W'(1);
    end

    // Timeout pending flag, cleared by a receive holding register read.
    always_ff @(posedge clk) begin
        if (!rst_n)      to_pend <= 1'b0;
        else if (hit)    to_pend <= 1'b1;
        else if (rx_pop) to_pend <= 1'b0;
    end
endmodule

// File: rtl/uirq_prio.sv
// Module: uirq_prio
// Fixed-priority selector over masked pending bits; index 0 is highest.
// Produces the status code, a one-hot winner and an any-pending flag.
module uirq_prio
    import uirq_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] en,
    output logic [3:0]      code,
    output logic [NSRC-1:0] sel,
    output logic            any
);
    logic [NSRC-1:0] masked;
    logic [2:0]      win;

    // Drop disabled sources before arbitration.
    always_comb masked = pend & en;

    // Scan from lowest to highest priority so the highest ends up chosen.
    always_comb begin
        win = 3'd7;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (masked[i]) win = i[2:0];
        end
    end

    // Outputs derived from the winner.
    always_comb begin
        any  = |masked;
        code = any ? src_code(win) : CODE_NONE;
        sel  = '0;
        if (any) sel[win] = 1'b1;
    end
endmodule

// File: rtl/uart_irq_status.sv
// Module: uart_irq_status
// Interrupt status byte and request line for one UART channel. Holds one
// pending bit per source, applies each source's clearing side effect and
// reports the highest-priority enabled pending source.
// Assumes all access inputs are single-cycle strobes.
module uart_irq_status
    import uirq_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int CLEN_W = 4,
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic [4:0]        src_en,
    input  logic [FLAG_W-1:0] line_flags,
    input  logic [FLAG_W-1:0] modem_flags,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  rx_trigger,
    input  logic              rx_push,
    input  logic              rx_pop,
    input  logic              bit_tick,
    input  logic [CLEN_W-1:0] char_bits,
    input  logic              tx_empty,
    input  logic              thr_wr,
    input  logic              isr_rd,
    input  logic              lsr_rd,
    input  logic              msr_rd,
    output logic [7:0]        isr_byte,
    output logic              irq
);
    localparam int NEV = 2;

    logic [NEV-1:0][FLAG_W-1:0] ev_flags;
    logic [NEV-1:0]             ev_clr;
    logic [NEV-1:0]             ev_pend;
    logic                       to_pend;
    logic                       rxrdy_q;
    logic                       tx_prev_q;
    logic                       tx_pend;
    logic [NSRC-1:0]            pend;
    logic [NSRC-1:0]            sel;
    logic [3:0]                 code;
    logic                       any;

    // Group the two flag-edge sources: slot 0 line, slot 1 modem.
    always_comb begin
        ev_flags[0] = line_flags;
        ev_flags[1] = modem_flags;
        ev_clr[0]   = lsr_rd;
        ev_clr[1]   = msr_rd;
    end

    generate
        for (genvar g = 0; g < NEV; g++) begin : g_ev
            uirq_edge_latch #(.W(FLAG_W)) u_ev (
                .clk   (clk),
                .rst_n (rst_n),
                .flags (ev_flags[g]),
                .clr   (ev_clr[g]),
                .pend  (ev_pend[g])
            );
        end
    endgenerate

    uirq_timeout #(.CNT_W(CNT_W), .CLEN_W(CLEN_W)) u_to (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en),
        .rx_count  (rx_count),
        .rx_push   (rx_push),
        .rx_pop    (rx_pop),
        .bit_tick  (bit_tick),
        .char_bits (char_bits),
        .to_pend   (to_pend)
    );

    // Receive ready level: trigger in FIFO mode, any data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       rxrdy_q <= 1'b0;
        else if (fifo_en) rxrdy_q <= (rx_count >= rx_trigger);
        else              rxrdy_q <= (rx_count != '0);
    end

    // Transmit-empty edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_prev_q <= 1'b0;
        else        tx_prev_q <= tx_empty;
    end

    // Transmit ready pending: clears win over a same-cycle rise.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  tx_pend <= 1'b0;
        else if (thr_wr || (isr_rd && sel[IDX_TXRDY])) tx_pend <= 1'b0;
        else if (tx_empty && !tx_prev_q)             tx_pend <= 1'b1;
    end

    // Assemble the pending vector in priority order.
    always_comb begin
        pend            = '0;
        pend[IDX_LINE]  = ev_pend[0];
        pend[IDX_RXTO]  = to_pend;
        pend[IDX_RXRDY] = rxrdy_q;
        pend[IDX_TXRDY] = tx_pend;
        pend[IDX_MODEM] = ev_pend[1];
    end

    uirq_prio u_prio (
        .pend (pend),
        .en   (src_en),
        .code (code),
        .sel  (sel),
        .any  (any)
    );

    // Status byte and interrupt line.
    always_comb begin
        isr_byte = {fifo_en, fifo_en, 2'b00, code};
        irq      = any;
    end
endmodule

// File: rtl/uirq_checker.sv
// Module: uirq_checker
// Temporal checks on the interrupt status controller's ports, bound to the
// top. Assumes strobes are single-cycle and flags are sampled per edge.
module uirq_checker #(
    parameter int FLAG_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_en,
    input logic [FLAG_W-1:0] line_flags,
    input logic [FLAG_W-1:0] modem_flags,
    input logic              lsr_rd,
    input logic              msr_rd,
    input logic              thr_wr,
    input logic              isr_rd,
    input logic              rx_pop,
    input logic [7:0]        isr_byte,
    input logic              irq
);
    logic [FLAG_W-1:0] line_prev;
    logic [FLAG_W-1:0] modem_prev;

    // Own copies of flag history for edge-free clear checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_prev  <= '0;
            modem_prev <= '0;
        end else begin
            line_prev  <= line_flags;
            modem_prev <= modem_flags;
        end
    end

    assert_fixed_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_byte[5:4] == 2'b00) && (isr_byte[7:6] == {2{fifo_en}}));

    assert_irq_matches_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (isr_byte[3:0] != 4'b0001));

    assert_line_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !(|(line_flags & ~line_prev))) |=> (isr_byte[3:0] != 4'b0110));

    assert_modem_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && !(|(modem_flags & ~modem_prev))) |=> (isr_byte[3:0] != 4'b0000));

    assert_timeout_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> (isr_byte[3:0] != 4'b1100));

    assert_tx_write_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> (isr_byte[3:0] != 4'b0010));

    assert_tx_read_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && isr_byte[3:0] == 4'b0010) |=> (isr_byte[3:0] != 4'b0010));
endmodule

bind uart_irq_status uirq_checker #(.FLAG_W(FLAG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en     (fifo_en),
    .line_flags  (line_flags),
    .modem_flags (modem_flags),
    .lsr_rd      (lsr_rd),
    .msr_rd      (msr_rd),
    .thr_wr      (thr_wr),
    .isr_rd      (isr_rd),
    .rx_pop      (rx_pop),
    .isr_byte    (isr_byte),
    .irq         (irq)
);

// File: tb/sim_uart_irq_status.sv
// Bench: sweeps every combination of pending sources against every enable
// mask, then walks each clearing path and timeout boundary.
module sim_uart_irq_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic [4:0] src_en = '0;
    logic [3:0] line_flags = '0;
    logic [3:0] modem_flags = '0;
    logic [4:0] rx_count = '0;
    logic [4:0] rx_trigger = 5'd4;
    logic       rx_push = 1'b0;
    logic       rx_pop = 1'b0;
    logic       bit_tick = 1'b0;
    logic [3:0] char_bits = 4'd5;
    logic       tx_empty = 1'b0;
    logic       thr_wr = 1'b0;
    logic       isr_rd = 1'b0;
    logic       lsr_rd = 1'b0;
    logic       msr_rd = 1'b0;
    logic [7:0] isr_byte;
    logic       irq;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    uart_irq_status u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .src_en(src_en),
        .line_flags(line_flags), .modem_flags(modem_flags),
        .rx_count(rx_count), .rx_trigger(rx_trigger), .rx_push(rx_push),
        .rx_pop(rx_pop), .bit_tick(bit_tick), .char_bits(char_bits),
        .tx_empty(tx_empty), .thr_wr(thr_wr), .isr_rd(isr_rd),
        .lsr_rd(lsr_rd), .msr_rd(msr_rd), .isr_byte(isr_byte), .irq(irq)
    );

    function automatic logic [3:0] exp_code(input logic [4:0] p, input logic [4:0] e);
        logic [3:0] tbl [5];
        tbl[0] = 4'b0110; tbl[1] = 4'b1100; tbl[2] = 4'b0100;
        tbl[3] = 4'b0010; tbl[4] = 4'b0000;
        for (int i = 0; i < 5; i++) if (p[i] && e[i]) return tbl[i];
        return 4'b0001;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_isr(input string req, input logic [7:0] exp, input logic exp_irq);
        chk((isr_byte == exp) && (irq == exp_irq), req, {irq, isr_byte}, {exp_irq, exp});
    endtask

    task automatic do_reset();
        rst_n = 1'b0; fifo_en = 1'b0; src_en = '0; line_flags = '0; modem_flags = '0;
        rx_count = '0; rx_trigger = 5'd4; rx_push = 0; rx_pop = 0; bit_tick = 0;
        char_bits = 4'd5; tx_empty = 0; thr_wr = 0; isr_rd = 0; lsr_rd = 0; msr_rd = 0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            step();
        end
        bit_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        // R1, R3: reset state with FIFOs off
        do_reset();
        src_en = 5'h1F;
        #1;
        chk_isr("R1", 8'h01, 1'b0);

        // R2, R4: every pending subset against every enable mask
        for (int s = 0; s < 32; s++) begin
            logic [4:0] sv;
            sv = 5'(s);
            do_reset();
            fifo_en = 1'b1;
            rx_count = sv[2] ? 5'd4 : (sv[1] ? 5'd2 : 5'd0);
            if (sv[0]) line_flags = 4'(1 << (s % 4));
            if (sv[4]) modem_flags = 4'b1000;
            if (sv[3]) tx_empty = 1'b1;
            step();
            line_flags = '0; modem_flags = '0;
            if (sv[1]) ticks(32);
            for (int e = 0; e < 32; e++) begin
                src_en = 5'(e);
                #1;
                chk_isr("R2/R4 sweep", {4'b1100, exp_code(sv, 5'(e))}, |(sv & 5'(e)));
            end
        end

        // R5: line error latch and clear
        do_reset(); fifo_en = 1'b1; src_en = 5'h1F;
        line_flags = 4'b0100; step(); line_flags = '0; step();
        chk_isr("R5 raise", 8'hC6, 1'b1);
        lsr_rd = 1; step(); lsr_rd = 0;
        chk_isr("R5 clear", 8'hC1, 1'b0);
        line_flags = 4'b1000; lsr_rd = 1; step(); lsr_rd = 0; line_flags = '0; step();
        chk_isr("R5 set wins", 8'hC6, 1'b1);

        // R6: modem latch and clear
        do_reset(); fifo_en = 1'b1; src_en = 5'h1F;
        modem_flags = 4'b0001; step(); modem_flags = '0; step();
        chk_isr("R6 raise", 8'hC0, 1'b1);
        msr_rd = 1; step(); msr_rd = 0;
        chk_isr("R6 clear", 8'hC1, 1'b0);
        modem_flags = 4'b0010; msr_rd = 1; step(); msr_rd = 0; modem_flags = '0; step();
        chk_isr("R6 set wins", 8'hC0, 1'b1);

        // R11, R12: transmit ready paths
        do_reset(); fifo_en = 1'b1; src_en = 5'h1F;
        tx_empty = 1; step();
        chk_isr("R11 raise", 8'hC2, 1'b1);
        thr_wr = 1; step(); thr_wr = 0;
        chk_isr("R11 write clears", 8'hC1, 1'b0);
        tx_empty = 0; step(); tx_empty = 1; step();
        chk_isr("R12 re-raise", 8'hC2, 1'b1);
        isr_rd = 1; step(); isr_rd = 0;
        chk_isr("R12 read clears", 8'hC1, 1'b0);
        tx_empty = 0; step();
        tx_empty = 1; line_flags = 4'b0001; step(); line_flags = '0;
        chk_isr("R12 line above tx", 8'hC6, 1'b1);
        isr_rd = 1; step(); isr_rd = 0;
        chk_isr("R12 read keeps line", 8'hC6, 1'b1);
        lsr_rd = 1; step(); lsr_rd = 0;
        chk_isr("R12 tx kept", 8'hC2, 1'b1);
        tx_empty = 0; thr_wr = 1; step(); thr_wr = 0;
        chk_isr("R11 write clears again", 8'hC1, 1'b0);
        tx_empty = 1; thr_wr = 1; step(); thr_wr = 0; step();
        chk_isr("R11 clear wins", 8'hC1, 1'b0);

        // R7: receive ready level
        do_reset(); fifo_en = 1'b1; src_en = 5'b00100; rx_trigger = 5'd4;
        rx_count = 5'd3; step();
        chk_isr("R7 below", 8'hC1, 1'b0);
        rx_count = 5'd4; step();
        chk_isr("R7 at trigger", 8'hC4, 1'b1);
        rx_count = 5'd9; step();
        chk_isr("R7 above", 8'hC4, 1'b1);
        rx_count = 5'd3; step();
        chk_isr("R7 drops", 8'hC1, 1'b0);
        fifo_en = 1'b0; rx_count = 5'd1; step();
        chk_isr("R7 non-FIFO R3", 8'h04, 1'b1);
        rx_count = 5'd0; step();
        chk_isr("R7 non-FIFO empty", 8'h01, 1'b0);

        // R8, R9, R10: timeout window
        do_reset(); fifo_en = 1'b1; src_en = 5'b00010; char_bits = 4'd5;
        rx_count = 5'd1; step();
        ticks(31);
        chk_isr("R8 one short", 8'hC1, 1'b0);
        ticks(1);
        chk_isr("R8 at limit", 8'hCC, 1'b1);
        rx_pop = 1; step(); rx_pop = 0;
        chk_isr("R10 pop clears", 8'hC1, 1'b0);
        ticks(20);
        rx_push = 1; step(); rx_push = 0;
        ticks(31);
        chk_isr("R9 push restarts", 8'hC1, 1'b0);
        ticks(1);
        chk_isr("R9 limit after push", 8'hCC, 1'b1);
        char_bits = 4'd8; rx_pop = 1; step(); rx_pop = 0;
        ticks(43);
        chk_isr("R8 8-bit one short", 8'hC1, 1'b0);
        ticks(1);
        chk_isr("R8 8-bit limit", 8'hCC, 1'b1);
        rx_pop = 1; step(); rx_pop = 0;
        fifo_en = 1'b0;
        ticks(50);
        chk_isr("R8 no count FIFO off", 8'h01, 1'b0);
        fifo_en = 1'b1; rx_count = 5'd0;
        ticks(50);
        chk_isr("R8 no count when empty", 8'hC1, 1'b0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule